// File: doc/BRIEF.md
# Clock Dither Pattern Controller

This block produces a time-varying tap code for a programmable delay line placed in a clock path. Moving the tap from cycle to cycle stretches and compresses clock edges, which spreads the energy of the clock harmonics over nearby frequencies. The analog delay line is not part of the block: a behavioural tap index and a derived delay value, in half-nanosecond units, stand in for it.

Software programs the block through a single write port with two registers. One is a step-size register, whose upper two bits select the delay per tap. The other is an enable register, whose top bit starts or stops dithering. The step size is captured only at the moment dithering starts, so changing it takes a fixed sequence: clear the enable, wait for the block to fall idle, write the new step, then enable again. A stop request does not take effect at once. The tap walks back down to the zero-delay base, and the block then drops its active flag. When the clock doubler is in use, the pattern advances on alternate cycles and targets the high phase. Otherwise it advances on every cycle and targets the low phase.

Top module: `dither_pattern_ctrl`

## Requirements
- R1: After reset, active, tap_idx, tap_update, phase_hi and delay_hns are 0, and step_sel is 2'b00.
- R2: A write with cfg_addr=1 and cfg_wdata[7]=1 while idle sets active in the next cycle, with tap_idx=0. It also loads step_sel from the last value written to cfg_wdata[7:6] at cfg_addr=0. The reserved code 2'b11 loads as 2'b00. Bits 5:0 of the step register and bits 6:0 of the enable register are ignored.
- R3: Writing the step register while active leaves step_sel unchanged. The new value takes effect only at the next enable edge.
- R4: The walk uses a 16-bit register that is seeded with 16'hACE1 at the enable edge. On each update cycle that is not draining, the feedback bit is the XOR of bits 15, 13, 12 and 10. The register shifts left and takes the feedback in bit 0. tap_idx then rises by 1 if the feedback is 1 and falls by 1 if it is 0, held within 0..26.
- R5: With doubler_on=0, tap_update is 1 on every active cycle. With doubler_on=1, a phase bit starts at 0 at the enable edge and toggles on each active cycle, and tap_update is 1 only when that bit is 1. phase_hi equals active AND doubler_on.
- R6: Writing cfg_wdata[7]=0 at cfg_addr=1 while active starts a drain. On each update cycle tap_idx falls by 1, the walk register holds, and active stays 1. Active clears one cycle after a draining cycle that sees tap_idx=0, well within 500 cycles.
- R7: Writing the enable bit as 1 during a drain cancels it. The walk then resumes from the current tap and walk register.
- R8: delay_hns equals tap_idx times 2 for step code 00, times 1 for code 01, and times 4 for code 10.
- R9: A disable write while idle has no effect: active and tap_idx stay 0.
- R10: While idle, tap_update is 0 and tap_idx stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 selects the step register, 1 selects the enable register |
| cfg_wdata | input | 8 | Write data |
| doubler_on | input | 1 | Clock doubler in use: advance on alternate cycles, high phase |
| tap_idx | output | 5 | Current delay tap, 0..26 |
| tap_update | output | 1 | The tap advances at the coming edge |
| phase_hi | output | 1 | Dither targets the high phase (doubler mode) |
| step_sel | output | 2 | Step code captured at the enable edge |
| delay_hns | output | 7 | Delay in half-nanosecond units |
| active | output | 1 | Dithering running or draining |

## Verification
The bench targets the sequences that a wrong design would mishandle. A step write during a run must not change the step; a design that resamples the step live would jump to a new delay scale mid-pattern. A disable must drain through every tap down to zero; a design that stops at once would leave a non-zero delay frozen, or drop active early. The bench also cancels a drain part-way, and a design that reseeds the walk or keeps draining would then move away from the reference walk. It also runs doubler mode, where an off-by-one in the phase bit shifts every update by a cycle. The reserved step code and a disable sent while idle are also exercised.

// File: rtl/dither_pkg.sv
package dither_pkg;

  typedef enum logic [1:0] {
    STEP_1NS  = 2'b00,
    STEP_HALF = 2'b01,
    STEP_2NS  = 2'b10,
    STEP_RSVD = 2'b11
  } step_e;

  // Replace the reserved code with the default 1 ns step.
  function automatic step_e step_legal(input logic [1:0] code);
    step_e s;
    s = step_e'(code);
    if (s == STEP_RSVD) s = STEP_1NS;
    return s;
  endfunction

  // Delay per tap in half-nanosecond units.
  function automatic logic [2:0] step_units(input step_e s);
    logic [2:0] u;
    case (s)
      STEP_HALF: u = 3'd1;
      STEP_2NS:  u = 3'd4;
      default:   u = 3'd2;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/dither_cfg.sv
module dither_cfg
  import dither_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_step,
  input  logic       wr_en,
  input  logic [1:0] wdata_hi,
  input  logic       tap_zero,
  output logic       active,
  output logic       draining,
  output logic       start,
  output step_e      step_sel
);

  logic  en_bit;
  logic  en_req;
  logic [1:0] stage_q, stage_n;
  logic  act_n, drain_n;
  step_e step_n;

  assign en_bit = wdata_hi[1];
  assign en_req = wr_en & en_bit;
  assign start  = ~active & en_req;

  always_comb begin
    stage_n = stage_q;
    act_n   = active;
    drain_n = draining;
    step_n  = step_sel;
    if (wr_step) stage_n = wdata_hi;
    if (!active) begin
      if (en_req) begin
        act_n   = 1'b1;
        drain_n = 1'b0;
        step_n  = step_legal(stage_q);
      end
    end else if (draining && tap_zero && !en_req) begin
      act_n   = 1'b0;
      drain_n = 1'b0;
    end else if (wr_en) begin
      drain_n = ~en_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= 2'b00;
      active   <= 1'b0;
      draining <= 1'b0;
      step_sel <= STEP_1NS;
    end else begin
      stage_q  <= stage_n;
      active   <= act_n;
      draining <= drain_n;
      step_sel <= step_n;
    end
  end

  // R3: captured step never moves during a run
  a_r3_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(step_sel));

  // R2: a run starts only after an enable request
  a_r2_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(wr_en && en_bit));

  // R6: a run ends only from a draining state at tap zero
  a_r6_stop_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(draining && tap_zero));

  // R9: disable while idle keeps the block idle
  a_r9_idle_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && wr_en && !en_bit) |=> !active);

endmodule

// File: rtl/dither_lfsr.sv
module dither_lfsr #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    SEED = 16'hACE1,
  parameter logic [W-1:0]    TAPS = 16'hB400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic shift,
  output logic fb
);

  logic [W-1:0] state_q, state_n;

  assign fb = ^(state_q & TAPS);

  always_comb begin
    state_n = state_q;
    if (load)       state_n = SEED;
    else if (shift) state_n = {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_n;
  end

  // R4: the walk register never locks up at all zeros
  a_r4_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/dither_walk.sv
module dither_walk
  import dither_pkg::*;
#(
  parameter int TAP_MAX = 26,
  localparam int TAPW   = $clog2(TAP_MAX + 1),
  localparam int DLYW   = $clog2(TAP_MAX * 4 + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            active,
  input  logic            draining,
  input  logic            doubler_on,
  input  logic            fb,
  input  step_e           step_sel,
  output logic [TAPW-1:0] tap,
  output logic            tap_update,
  output logic            lfsr_shift,
  output logic            phase_hi,
  output logic [DLYW-1:0] delay
);

  localparam logic [TAPW-1:0] TOP = TAPW'(TAP_MAX);

  logic            ph_q, ph_n;
  logic [TAPW-1:0] tap_n;
  logic [TAPW-1:0] tap_up, tap_dn;

  assign tap_update = active & (~doubler_on | ph_q);
  assign lfsr_shift = tap_update & ~draining;
  assign phase_hi   = active & doubler_on;
  assign tap_up     = (tap == TOP) ? tap : tap + 1'b1;
  assign tap_dn     = (tap == '0)  ? tap : tap - 1'b1;
  assign delay      = DLYW'(tap) * DLYW'(step_units(step_sel));

  always_comb begin
    tap_n = tap;
    ph_n  = ph_q;
    if (start) begin
      tap_n = '0;
      ph_n  = 1'b0;
    end else if (active) begin
      ph_n = ~ph_q;
      if (tap_update) tap_n = (draining || !fb) ? tap_dn : tap_up;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap  <= '0;
      ph_q <= 1'b0;
    end else begin
      tap  <= tap_n;
      ph_q <= ph_n;
    end
  end

  // R4: tap stays inside its range
  a_r4_tap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tap <= TOP);

  // R6: each drain update lowers the tap by one, floored at zero
  a_r6_drain_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_update && draining && tap != '0) |=> (tap == $past(tap) - 1'b1));

  // R10: idle means no updates and the base delay
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!tap_update && tap == '0));

  // R5: doubler mode never updates on two cycles in a row
  a_r5_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (doubler_on && $past(doubler_on) && $past(tap_update)) |-> !tap_update);

endmodule

// File: rtl/dither_pattern_ctrl.sv
module dither_pattern_ctrl
  import dither_pkg::*;
#(
  parameter int TAP_MAX = 26,
  parameter int LFSR_W  = 16,
  localparam int TAPW   = $clog2(TAP_MAX + 1),
  localparam int DLYW   = $clog2(TAP_MAX * 4 + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic            cfg_addr,
  input  logic [7:0]      cfg_wdata,
  input  logic            doubler_on,
  output logic [TAPW-1:0] tap_idx,
  output logic            tap_update,
  output logic            phase_hi,
  output logic [1:0]      step_sel,
  output logic [DLYW-1:0] delay_hns,
  output logic            active
);

  logic [1:0] rst_sync;
  logic       rst_ni;
  logic       draining, start, fb, lfsr_shift;
  step_e      step_q;
  logic       unused_rsvd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign unused_rsvd = ^cfg_wdata[5:0];

  dither_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_ni),
    .wr_step  (cfg_wr & ~cfg_addr),
    .wr_en    (cfg_wr & cfg_addr),
    .wdata_hi (cfg_wdata[7:6]),
    .tap_zero (tap_idx == '0),
    .active   (active),
    .draining (draining),
    .start    (start),
    .step_sel (step_q)
  );

  dither_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_ni),
    .load  (start),
    .shift (lfsr_shift),
    .fb    (fb)
  );

  dither_walk #(.TAP_MAX(TAP_MAX)) u_walk (
    .clk        (clk),
    .rst_n      (rst_ni),
    .start      (start),
    .active     (active),
    .draining   (draining),
    .doubler_on (doubler_on),
    .fb         (fb),
    .step_sel   (step_q),
    .tap        (tap_idx),
    .tap_update (tap_update),
    .lfsr_shift (lfsr_shift),
    .phase_hi   (phase_hi),
    .delay      (delay_hns)
  );

  assign step_sel = step_q;

endmodule

// File: tb/dither_pattern_ctrl_bench.sv
module dither_pattern_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic       cfg_addr;
  logic [7:0] cfg_wdata;
  logic       doubler_on;
  logic [4:0] tap_idx;
  logic       tap_update, phase_hi, active;
  logic [1:0] step_sel;
  logic [6:0] delay_hns;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int m_act = 0, m_drain = 0, m_tap = 0, m_ph = 0, m_step = 0, m_stage = 0;
  int m_lfsr = 'hACE1;

  always #4 clk = ~clk;

  dither_pattern_ctrl u_dither_pattern_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .doubler_on(doubler_on), .tap_idx(tap_idx),
    .tap_update(tap_update), .phase_hi(phase_hi), .step_sel(step_sel),
    .delay_hns(delay_hns), .active(active)
  );

  function automatic int units(input int s);
    if (s == 1) return 1;
    if (s == 2) return 4;
    return 2;
  endfunction

  task automatic chk(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  task automatic compare_all();
    int e_upd;
    e_upd = (m_act != 0) && (doubler_on == 1'b0 || m_ph != 0);
    chk("R6 active", active, m_act);
    chk("R4 tap_idx", tap_idx, m_tap);
    chk("R3 step_sel", step_sel, m_step);
    chk("R5 tap_update", tap_update, e_upd);
    chk("R5 phase_hi", phase_hi, (m_act != 0) && doubler_on);
    chk("R8 delay_hns", delay_hns, m_tap * units(m_step));
  endtask

  task automatic model_step(input int wr, input int addr, input int d);
    int en_req, adv, fbit;
    en_req = wr && addr == 1 && ((d >> 7) & 1);
    adv    = m_act && (!doubler_on || m_ph);
    if (!m_act) begin
      if (en_req) begin
        m_act = 1; m_drain = 0; m_tap = 0; m_ph = 0; m_lfsr = 'hACE1;
        m_step = (m_stage == 3) ? 0 : m_stage;
      end
    end else begin
      m_ph = 1 - m_ph;
      if (adv) begin
        if (m_drain) begin
          if (m_tap > 0) m_tap--;
        end else begin
          fbit = ((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1;
          m_lfsr = ((m_lfsr << 1) | fbit) & 'hFFFF;
          if (fbit) begin if (m_tap < 26) m_tap++; end
          else      begin if (m_tap > 0)  m_tap--; end
        end
      end
    end
    if (wr && addr == 0) m_stage = (d >> 6) & 3;
  endtask

  // drive, compare before the edge, step model at the edge
  task automatic cyc(input int wr, input int addr, input int d);
    int old_act, old_drain, old_tap;
    cfg_wr = wr[0]; cfg_addr = addr[0]; cfg_wdata = d[7:0];
    #2;
    compare_all();
    old_act = m_act; old_drain = m_drain; old_tap = m_tap;
    @(posedge clk);
    model_step(wr, addr, d);
    if (old_act && old_drain && old_tap == 0 && !(wr && addr == 1 && ((d >> 7) & 1))) begin
      m_act = 0; m_drain = 0;
    end else if (old_act && wr && addr == 1) begin
      m_drain = ((d >> 7) & 1) ? 0 : 1;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  task automatic drain_out(input string req);
    int n;
    n = 0;
    while (active && n < 200) begin cyc(0, 0, 0); n++; end
    chk(req, (n <= 60) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0; doubler_on = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 active", active, 0);
    chk("R1 tap_idx", tap_idx, 0);
    chk("R1 step_sel", step_sel, 0);
    chk("R1 tap_update", tap_update, 0);
    chk("R1 delay_hns", delay_hns, 0);

    // R2: enable with 1 ns step, reserved bits set in both registers
    cyc(1, 0, 'h3F);
    cyc(1, 1, 'hFF);
    chk("R2 active after enable", active, 1);
    chk("R2 tap_idx after enable", tap_idx, 0);
    idle(100);
    // R3: step write during a run is held off
    cyc(1, 0, 'h80);
    idle(5);
    chk("R3 step_sel unchanged", step_sel, 0);
    // R6: drain
    cyc(1, 1, 'h00);
    chk("R6 still active after disable", active, 1);
    drain_out("R6 drains within bound");
    chk("R6 tap zero after drain", tap_idx, 0);
    // R9: disable while idle
    cyc(1, 1, 'h00);
    idle(3);
    chk("R9 active stays low", active, 0);
    chk("R10 tap stays zero idle", tap_idx, 0);
    // R3/R2: new step taken at next enable, doubler mode (R5)
    doubler_on = 1;
    cyc(1, 1, 'h80);
    chk("R3 step_sel after re-enable", step_sel, 2);
    idle(80);
    // R7: disable then cancel
    cyc(1, 1, 'h00);
    idle(3);
    cyc(1, 1, 'h80);
    chk("R7 active after cancel", active, 1);
    idle(60);
    cyc(1, 1, 'h00);
    drain_out("R6 drain in doubler mode");
    // R2: reserved step code loads as 00
    doubler_on = 0;
    cyc(1, 0, 'hC0);
    cyc(1, 1, 'h80);
    chk("R2 reserved code loads 00", step_sel, 0);
    idle(40);
    cyc(1, 1, 'h00);
    drain_out("R6 drain after reserved");
    // R8: half-ns step
    cyc(1, 0, 'h40);
    cyc(1, 1, 'h80);
    chk("R8 step_sel half", step_sel, 1);
    idle(120);
    cyc(1, 1, 'h00);
    drain_out("R6 final drain");
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule